// File: doc/BRIEF.md
# Prebias-Safe Startup and Power-Good Sequencer

This block sequences the start of a step-down regulator once it is enabled. While the block is off, it holds the soft-start node in discharge and drives power-good low. When the enable, supply and temperature conditions are all good, it first waits out a discharge interval. It then releases soft-start and keeps both power switches off. This protects an output that already carries a voltage: the output is not pulled down. Switching begins when the soft-start ramp rises above the feedback voltage. If the output sits above its target, switching is forced to start when the ramp reaches a fixed forced-start level.

From the first switching pulse, the block raises a code for the low-side reverse (sink) current limit. The code goes from its lowest value to its maximum in equal steps over a fixed number of clock cycles. Power-good is tracked with hysteresis between a rise comparator and a fall comparator, and only while the converter is switching. The output is open-drain style: a high level requests the pull-down. A thermal trip is latched until the cool-down comparator reports that the die has cooled. A restart request from the protection logic forces a full off / discharge / restart cycle.

All analog ramps and comparators are outside the block. They arrive as single-bit flags that are synchronous to the clock.

Top module: `startup_sequencer`

## Requirements
- R1: While reset is active, ssDischarge=1, switchEn=0, sinkLimCode=0 and pgoodPullDown=1. In any cycle where enable=0, uvloActive=1, thermHot=1 or restartReq=1 is sampled at a clock edge, these same four values hold from the next cycle onwards.
- R2: After entering the off state, ssDischarge stays 1 until DISCH_CYCLES consecutive fault-free clock edges have passed. It falls to 0 in the cycle after the last of them.
- R3: After discharge ends, switchEn stays 0 until rampAboveFb or rampAtForce is sampled 1. switchEn is 1 from the next cycle.
- R4: rampAtForce alone (with rampAboveFb=0) starts switching, so an output prebiased above target still starts.
- R5: sinkLimCode is 0 in the first switching cycle. It rises by exactly 1 every STEP_CYCLES = RAMP_CYCLES/LIM_STEPS cycles. It reaches LIM_STEPS after LIM_STEPS*STEP_CYCLES cycles, holds there while switching continues, and never exceeds LIM_STEPS.
- R6: While switching and fault-free, pgoodPullDown falls to 0 in the cycle after fbAbovePgRise is sampled 1. It rises to 1 in the cycle after fbBelowPgFall is sampled 1. It holds when neither flag is set. When both flags are 1, fbBelowPgFall wins.
- R7: pgoodPullDown is 1 whenever switchEn is 0, including the prebias wait with fbAbovePgRise=1. It is also 1 in the first switching cycle.
- R8: A single cycle of thermHot keeps the block off until thermCool is sampled 1 with thermHot=0. The DISCH_CYCLES discharge count begins only after that edge.
- R9: A one-cycle restartReq stops switching, re-runs the discharge interval and then restarts on a ramp crossing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Regulator enable |
| uvloActive | input | 1 | Input supply below the undervoltage threshold |
| thermHot | input | 1 | Die temperature above the trip level |
| thermCool | input | 1 | Die temperature below the restart level |
| restartReq | input | 1 | Restart request from the protection controller |
| rampAboveFb | input | 1 | Soft-start ramp above feedback |
| rampAtForce | input | 1 | Soft-start ramp at or above the forced-start level |
| fbAbovePgRise | input | 1 | Feedback above the power-good rise threshold |
| fbBelowPgFall | input | 1 | Feedback below the power-good fall threshold |
| switchEn | output | 1 | Power switches allowed to switch |
| sinkLimCode | output | CODE_W | Low-side sink current limit code, 0 to LIM_STEPS |
| ssDischarge | output | 1 | Request to discharge the soft-start node |
| pgoodPullDown | output | 1 | 1 = pull power-good low |

## Verification
The assertions check the following on every cycle:
- the forced-off response to any fault;
- that switching never starts without a ramp-crossing flag in the previous cycle;
- that the limit code starts at zero, moves by at most one and keeps exactly STEP_CYCLES cycles between steps;
- that power-good changes only on the matching comparator, and stays low when not switching.

Only the bench scenarios show the following:
- the exact length of the discharge interval;
- the latched thermal hold and its release on the cool flag;
- the restart cycle;
- the full ramp reaching its maximum at the expected cycle.

The bench's cycle model compares all outputs under random faults and flags.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_HOLD = 2'd1,
    ST_RAMP = 2'd2,
    ST_RUN  = 2'd3
  } seqState_t;

  // control-to-datapath strobes
  typedef struct packed {
    logic dischClr;
    logic dischInc;
    logic rampClr;
    logic rampInc;
    logic pgEval;
  } seqStrobe_t;

endpackage

// File: rtl/seq_datapath.sv
module seq_datapath
  import seq_pkg::*;
#(
  parameter int DISCH_CYCLES = 256,
  parameter int RAMP_CYCLES  = 35000,
  parameter int LIM_STEPS    = 8,
  localparam int CODE_W      = $clog2(LIM_STEPS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic              thermHot,
  input  logic              thermCool,
  input  logic              fbAbovePgRise,
  input  logic              fbBelowPgFall,
  output logic              dischDone,
  output logic              rampLast,
  output logic              thermLatched,
  output logic [CODE_W-1:0] sinkLimCode,
  output logic              pgood
);

  localparam int STEP_CYCLES = (RAMP_CYCLES / LIM_STEPS > 0) ? RAMP_CYCLES / LIM_STEPS : 1;
  localparam int STEP_W      = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
  localparam int DISCH_W     = (DISCH_CYCLES > 1) ? $clog2(DISCH_CYCLES) : 1;

  logic [DISCH_W-1:0] dischCnt;
  logic [STEP_W-1:0]  stepCnt;
  logic [CODE_W-1:0]  limCode;
  logic               stepWrap;

  // discharge interval counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              dischCnt <= '0;
    else if (strb.dischClr) dischCnt <= '0;
    else if (strb.dischInc) dischCnt <= dischCnt + 1'b1;
  end

  assign dischDone = (dischCnt == DISCH_W'(DISCH_CYCLES - 1));

  // sink-limit ramp: one code step per STEP_CYCLES cycles
  assign stepWrap = (stepCnt == STEP_W'(STEP_CYCLES - 1));
  assign rampLast = stepWrap && (limCode == CODE_W'(LIM_STEPS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepCnt <= '0;
      limCode <= '0;
    end else if (strb.rampClr) begin
      stepCnt <= '0;
      limCode <= '0;
    end else if (strb.rampInc) begin
      if (stepWrap) begin
        stepCnt <= '0;
        limCode <= limCode + 1'b1;
      end else begin
        stepCnt <= stepCnt + 1'b1;
      end
    end
  end

  assign sinkLimCode = limCode;

  // power-good hysteresis, fall comparator has priority
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             pgood <= 1'b0;
    else if (!strb.pgEval) pgood <= 1'b0;
    else if (fbBelowPgFall) pgood <= 1'b0;
    else if (fbAbovePgRise) pgood <= 1'b1;
  end

  // thermal trip latch, released by the cool-down flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          thermLatched <= 1'b0;
    else if (thermHot)  thermLatched <= 1'b1;
    else if (thermCool) thermLatched <= 1'b0;
  end

endmodule

// File: rtl/seq_control.sv
module seq_control
  import seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       uvloActive,
  input  logic       thermHot,
  input  logic       thermLatched,
  input  logic       restartReq,
  input  logic       rampAboveFb,
  input  logic       rampAtForce,
  input  logic       dischDone,
  input  logic       rampLast,
  output seqStrobe_t strb,
  output logic       switchEn,
  output logic       ssDischarge
);

  seqState_t state;
  seqState_t stateNext;
  logic      fault;

  assign fault = !enable || uvloActive || thermHot || thermLatched || restartReq;

  always_comb begin
    stateNext = state;
    if (fault) begin
      stateNext = ST_OFF;
    end else begin
      unique case (state)
        ST_OFF:  if (dischDone) stateNext = ST_HOLD;
        ST_HOLD: if (rampAboveFb || rampAtForce) stateNext = ST_RAMP;
        ST_RAMP: if (rampLast) stateNext = ST_RUN;
        ST_RUN:  stateNext = ST_RUN;
        default: stateNext = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_OFF;
    else       state <= stateNext;
  end

  always_comb begin
    strb.dischClr = fault || (state != ST_OFF);
    strb.dischInc = !fault && (state == ST_OFF);
    strb.rampClr  = fault || (state == ST_OFF) || (state == ST_HOLD);
    strb.rampInc  = !fault && (state == ST_RAMP);
    strb.pgEval   = !fault && ((state == ST_RAMP) || (state == ST_RUN));
  end

  assign switchEn    = (state == ST_RAMP) || (state == ST_RUN);
  assign ssDischarge = (state == ST_OFF);

endmodule

// File: rtl/startup_sequencer.sv
module startup_sequencer
  import seq_pkg::*;
#(
  parameter int DISCH_CYCLES = 256,
  parameter int RAMP_CYCLES  = 35000,
  parameter int LIM_STEPS    = 8,
  localparam int CODE_W      = $clog2(LIM_STEPS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              uvloActive,
  input  logic              thermHot,
  input  logic              thermCool,
  input  logic              restartReq,
  input  logic              rampAboveFb,
  input  logic              rampAtForce,
  input  logic              fbAbovePgRise,
  input  logic              fbBelowPgFall,
  output logic              switchEn,
  output logic [CODE_W-1:0] sinkLimCode,
  output logic              ssDischarge,
  output logic              pgoodPullDown
);

  seqStrobe_t strb;
  logic       dischDone;
  logic       rampLast;
  logic       thermLatched;
  logic       pgood;

  seq_control uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .enable       (enable),
    .uvloActive   (uvloActive),
    .thermHot     (thermHot),
    .thermLatched (thermLatched),
    .restartReq   (restartReq),
    .rampAboveFb  (rampAboveFb),
    .rampAtForce  (rampAtForce),
    .dischDone    (dischDone),
    .rampLast     (rampLast),
    .strb         (strb),
    .switchEn     (switchEn),
    .ssDischarge  (ssDischarge)
  );

  seq_datapath #(
    .DISCH_CYCLES (DISCH_CYCLES),
    .RAMP_CYCLES  (RAMP_CYCLES),
    .LIM_STEPS    (LIM_STEPS)
  ) uData (
    .clk           (clk),
    .rstN          (rstN),
    .strb          (strb),
    .thermHot      (thermHot),
    .thermCool     (thermCool),
    .fbAbovePgRise (fbAbovePgRise),
    .fbBelowPgFall (fbBelowPgFall),
    .dischDone     (dischDone),
    .rampLast      (rampLast),
    .thermLatched  (thermLatched),
    .sinkLimCode   (sinkLimCode),
    .pgood         (pgood)
  );

  assign pgoodPullDown = !pgood;

endmodule

// File: rtl/startup_sequencer_chk.sv
module startup_sequencer_chk #(
  parameter int RAMP_CYCLES = 35000,
  parameter int LIM_STEPS   = 8,
  parameter int CODE_W      = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              enable,
  input logic              uvloActive,
  input logic              thermHot,
  input logic              restartReq,
  input logic              rampAboveFb,
  input logic              rampAtForce,
  input logic              fbAbovePgRise,
  input logic              fbBelowPgFall,
  input logic              switchEn,
  input logic [CODE_W-1:0] sinkLimCode,
  input logic              ssDischarge,
  input logic              pgoodPullDown
);

  localparam int STEP_CYCLES = (RAMP_CYCLES / LIM_STEPS > 0) ? RAMP_CYCLES / LIM_STEPS : 1;

  logic [CODE_W-1:0] lastCode;
  logic [31:0]       holdCnt;

  // cycles the current code value has been held while switching
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastCode <= '0;
      holdCnt  <= '0;
    end else begin
      lastCode <= sinkLimCode;
      if (!switchEn)                    holdCnt <= '0;
      else if (sinkLimCode != lastCode) holdCnt <= 32'd1;
      else                              holdCnt <= holdCnt + 32'd1;
    end
  end

  AST_FAULT_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (!enable || uvloActive || thermHot || restartReq) |=>
      (ssDischarge && !switchEn && pgoodPullDown && sinkLimCode == '0)); // R1

  AST_START_NEEDS_CROSS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(switchEn) |-> $past(rampAboveFb || rampAtForce)); // R3

  AST_CODE_START_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    $rose(switchEn) |-> (sinkLimCode == '0)); // R5

  AST_CODE_STEP_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (switchEn && $past(switchEn)) |->
      (sinkLimCode == $past(sinkLimCode) || sinkLimCode == CODE_W'($past(sinkLimCode) + 1'b1))); // R5

  AST_CODE_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    (switchEn && $past(switchEn) && sinkLimCode != lastCode) |-> (holdCnt == 32'(STEP_CYCLES))); // R5

  AST_CODE_MAX: assert property (@(posedge clk) disable iff (!rstN)
    32'(sinkLimCode) <= 32'(LIM_STEPS)); // R5

  AST_PG_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pgoodPullDown) |-> $past(fbAbovePgRise && !fbBelowPgFall && switchEn)); // R6

  AST_PG_FALL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pgoodPullDown) |->
      $past(fbBelowPgFall || !switchEn || !enable || uvloActive || thermHot || restartReq)); // R6

  AST_PG_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !switchEn |-> pgoodPullDown); // R7

endmodule

bind startup_sequencer startup_sequencer_chk #(
  .RAMP_CYCLES (RAMP_CYCLES),
  .LIM_STEPS   (LIM_STEPS),
  .CODE_W      (CODE_W)
) uChk (
  .clk           (clk),
  .rstN          (rstN),
  .enable        (enable),
  .uvloActive    (uvloActive),
  .thermHot      (thermHot),
  .restartReq    (restartReq),
  .rampAboveFb   (rampAboveFb),
  .rampAtForce   (rampAtForce),
  .fbAbovePgRise (fbAbovePgRise),
  .fbBelowPgFall (fbBelowPgFall),
  .switchEn      (switchEn),
  .sinkLimCode   (sinkLimCode),
  .ssDischarge   (ssDischarge),
  .pgoodPullDown (pgoodPullDown)
);

// File: tb/tb_startup_sequencer.sv
module tb_startup_sequencer;

  localparam int DISCH = 4;
  localparam int RAMP  = 64;
  localparam int STEPS = 8;
  localparam int STEP  = RAMP / STEPS;
  localparam int CW    = $clog2(STEPS + 1);

  logic clk, rstN;
  logic enable, uvloActive, thermHot, thermCool, restartReq;
  logic rampAboveFb, rampAtForce, fbAbovePgRise, fbBelowPgFall;
  logic switchEn, ssDischarge, pgoodPullDown;
  logic [CW-1:0] sinkLimCode;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  startup_sequencer #(
    .DISCH_CYCLES (DISCH),
    .RAMP_CYCLES  (RAMP),
    .LIM_STEPS    (STEPS)
  ) dut (
    .clk           (clk),
    .rstN          (rstN),
    .enable        (enable),
    .uvloActive    (uvloActive),
    .thermHot      (thermHot),
    .thermCool     (thermCool),
    .restartReq    (restartReq),
    .rampAboveFb   (rampAboveFb),
    .rampAtForce   (rampAtForce),
    .fbAbovePgRise (fbAbovePgRise),
    .fbBelowPgFall (fbBelowPgFall),
    .switchEn      (switchEn),
    .sinkLimCode   (sinkLimCode),
    .ssDischarge   (ssDischarge),
    .pgoodPullDown (pgoodPullDown)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // cycle model built from the requirements: 0 off, 1 hold, 2 ramp, 3 run
  int mState, mDisch, mStep, mCode;
  bit mPg, mTherm, mFault;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mState <= 0; mDisch <= 0; mStep <= 0; mCode <= 0; mPg <= 0; mTherm <= 0;
    end else begin
      mFault = !enable || uvloActive || thermHot || mTherm || restartReq;
      mTherm <= thermHot ? 1'b1 : (thermCool ? 1'b0 : mTherm);
      if (mFault) begin
        mState <= 0; mDisch <= 0; mStep <= 0; mCode <= 0;
      end else begin
        case (mState)
          0: if (mDisch == DISCH - 1) begin mState <= 1; mDisch <= 0; end
             else mDisch <= mDisch + 1;
          1: if (rampAboveFb || rampAtForce) begin mState <= 2; mStep <= 0; mCode <= 0; end
          2: if (mStep == STEP - 1) begin
               mStep <= 0;
               mCode <= mCode + 1;
               if (mCode + 1 == STEPS) mState <= 3;
             end else mStep <= mStep + 1;
          default: ;
        endcase
      end
      if (!mFault && mState >= 2) begin
        if (fbBelowPgFall) mPg <= 1'b0;
        else if (fbAbovePgRise) mPg <= 1'b1;
      end else begin
        mPg <= 1'b0;
      end
    end
  end

  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk("R3 model switchEn", int'(switchEn), int'(mState >= 2));
      chk("R2 model ssDischarge", int'(ssDischarge), int'(mState == 0));
      chk("R5 model sinkLimCode", int'(sinkLimCode), mCode);
      chk("R6 model pgoodPullDown", int'(pgoodPullDown), int'(!mPg));
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 0; enable = 0; uvloActive = 0; thermHot = 0; thermCool = 1; restartReq = 0;
    rampAboveFb = 0; rampAtForce = 0; fbAbovePgRise = 0; fbBelowPgFall = 0;
    step(3);
    chk("R1 reset ssDischarge", int'(ssDischarge), 1);
    chk("R1 reset switchEn", int'(switchEn), 0);
    chk("R1 reset pgoodPullDown", int'(pgoodPullDown), 1);
    chk("R1 reset sinkLimCode", int'(sinkLimCode), 0);
    rstN = 1;
    step(2);
    chk("R1 disabled stays off", int'(ssDischarge), 1);

    enable = 1;
    step(DISCH - 1);
    chk("R2 discharge still held", int'(ssDischarge), 1);
    step(1);
    chk("R2 discharge released", int'(ssDischarge), 0);
    chk("R3 no switching in hold", int'(switchEn), 0);

    fbAbovePgRise = 1;
    step(5);
    chk("R7 prebias hold switchEn", int'(switchEn), 0);
    chk("R7 prebias hold pgood low", int'(pgoodPullDown), 1);

    rampAtForce = 1;
    step(1);
    rampAtForce = 0;
    chk("R4 forced start switchEn", int'(switchEn), 1);
    chk("R5 first code zero", int'(sinkLimCode), 0);
    chk("R7 first switch cycle pgood low", int'(pgoodPullDown), 1);
    step(1);
    chk("R6 pgood asserts", int'(pgoodPullDown), 0);
    step(STEP - 2);
    chk("R5 code before first step", int'(sinkLimCode), 0);
    step(1);
    chk("R5 code first step", int'(sinkLimCode), 1);
    step(RAMP - STEP - 1);
    chk("R5 code before max", int'(sinkLimCode), STEPS - 1);
    step(1);
    chk("R5 code at max", int'(sinkLimCode), STEPS);
    step(20);
    chk("R5 code holds max", int'(sinkLimCode), STEPS);

    fbAbovePgRise = 0;
    step(3);
    chk("R6 pgood holds high", int'(pgoodPullDown), 0);
    fbBelowPgFall = 1;
    step(1);
    chk("R6 pgood deasserts", int'(pgoodPullDown), 1);
    fbBelowPgFall = 0;
    step(3);
    chk("R6 pgood holds low", int'(pgoodPullDown), 1);
    fbBelowPgFall = 1; fbAbovePgRise = 1;
    step(1);
    chk("R6 fall wins over rise", int'(pgoodPullDown), 1);
    fbBelowPgFall = 0;
    step(1);
    chk("R6 pgood reasserts", int'(pgoodPullDown), 0);

    thermHot = 1; thermCool = 0;
    step(1);
    thermHot = 0;
    chk("R8 thermal trip switchEn", int'(switchEn), 0);
    chk("R8 thermal trip pgood", int'(pgoodPullDown), 1);
    step(10);
    chk("R8 latched while warm", int'(ssDischarge), 1);
    thermCool = 1;
    step(1 + DISCH - 1);
    chk("R8 discharge restarts after cool", int'(ssDischarge), 1);
    step(1);
    chk("R8 released after cool", int'(ssDischarge), 0);
    chk("R7 hold pgood low", int'(pgoodPullDown), 1);

    rampAboveFb = 1;
    step(1);
    chk("R3 crossing starts switching", int'(switchEn), 1);
    restartReq = 1;
    step(1);
    restartReq = 0;
    chk("R9 restart stops switching", int'(switchEn), 0);
    chk("R9 restart discharges", int'(ssDischarge), 1);
    step(DISCH - 1);
    chk("R9 discharge interval", int'(ssDischarge), 1);
    step(1);
    chk("R9 discharge ends", int'(ssDischarge), 0);
    step(1);
    chk("R9 switching restarts", int'(switchEn), 1);

    uvloActive = 1;
    step(1);
    uvloActive = 0; rampAboveFb = 0;
    chk("R1 undervoltage stops switching", int'(switchEn), 0);
    chk("R1 undervoltage discharges", int'(ssDischarge), 1);

    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      enable        = ($urandom_range(0, 999) >= 3);
      uvloActive    = ($urandom_range(0, 999) < 3);
      thermHot      = ($urandom_range(0, 999) < 2);
      thermCool     = ($urandom_range(0, 99) < 30);
      restartReq    = ($urandom_range(0, 999) < 2);
      rampAboveFb   = ($urandom_range(0, 99) < 15);
      rampAtForce   = ($urandom_range(0, 99) < 4);
      fbAbovePgRise = ($urandom_range(0, 99) < 30);
      fbBelowPgFall = ($urandom_range(0, 99) < 20);
    end
    step(2);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule